// File: doc/BRIEF.md
# AXI4 Burst Self-Test Master

This block is a self-starting AXI4 master that exercises a memory-mapped system of eight targets and reports a single verdict. When reset is released it writes one 128-beat incrementing burst to the base address of every target, one burst at a time. It then reads each burst back in the same target order and compares every returned beat with a word it regenerates from a fixed pattern. No copy of the written data is kept. Error responses and misplaced read-burst terminations are treated as faults, just like data mismatches.

The sequencer is a state machine with seven states. IDLE is the one cycle after reset and always moves to AW. AW holds the write address until it is accepted and then moves to W. W streams the beats and moves to B after the final beat. B waits for the write response. If more targets remain it returns to AW for the next target; otherwise it moves to AR with the target index back at zero. AR holds the read address until it is accepted and then moves to R. R accepts the beats and, after the final beat, either returns to AR for the next target or enters DONE. DONE is terminal and is left only by reset. Status outputs done, pass and fail, plus a count of error responses, are intended to drive board indicators or a supervising controller.

Top module: `axi_burst_selftest`

## Requirements
- R1: After reset the block issues exactly eight write bursts, one per target, at addresses 0x00000000, 0x10000000, 0x11000000, 0x11100000, 0x20000000, 0x30000000, 0x40000000, 0x41000000 in that order. Every write address carries length 127, burst type INCR (2'b01) and size log2(DATA_W/8). The address stays stable while it waits to be accepted.
- R2: Write beat b (0..127) of target i carries bits [31:24] = i, bits [23:16] = 0xC3, bits [15:0] = b and all other bits zero. All byte strobes are set, and WLAST is high on beat 127 only.
- R3: Each write burst's response is received before the next write address is issued. No read address is issued until all eight write responses have arrived. Reads then visit the same eight addresses in the same order, with length 127, INCR type and the same size.
- R4: Each read beat is compared with the R2 word for its target and beat number. Any difference makes the final verdict fail.
- R5: A response code other than OKAY (2'b00) on the write-response channel, or on any read beat, makes the verdict fail. The error count rises by one per such response and saturates at its maximum.
- R6: Read-burst length is set by the beat count, not by RLAST. RLAST low on beat 127, or high on any earlier beat, makes the verdict fail.
- R7: done rises after the final beat of the eighth read burst. pass is high exactly when no R4–R6 fault occurred and fail is high otherwise. pass and fail are never both high, and both stay low while done is low.
- R8: Once done is high, done, pass, fail and the error count hold their values and no further address or data valid is driven, until reset.
- R9: Reset (rst_n low, asynchronous) clears all status outputs and the error count, drops every valid and ready output, and a new run starts again from the first target.
- R10: At most one of write-address valid, write-data valid, write-response ready, read-address valid and read-data ready is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Final write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rlast | input | 1 | Final read beat flag |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| test_done | output | 1 | Run finished |
| test_pass | output | 1 | Run finished with no fault |
| test_fail | output | 1 | Run finished with at least one fault |
| resp_err_count | output | ERR_W | Number of non-OKAY responses seen |

## Verification
A wrong target index shows up at once as an address out of order on the next address handshake. It also appears in the top byte of the very next write beat. A beat counter that is off by one moves WLAST away from beat 127 within the current burst. On reads, the same fault turns into a data or RLAST mismatch that can only be seen through fail once done rises. Sticky-fault or verdict errors appear only at the end of a run, as a wrong pass/fail pair or a changing status after done. The bench therefore injects one fault of each kind per run and checks the final verdict and the error count.

// File: rtl/bst_pkg.sv
`timescale 1ns/1ps
package bst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AW,
        ST_W,
        ST_B,
        ST_AR,
        ST_R,
        ST_DONE
    } bst_state_e;

    localparam int unsigned BST_NUM_TGT = 8;
    localparam int unsigned BST_TGT_W   = $clog2(BST_NUM_TGT);

    // Start address of each target, visited in index order.
    function automatic logic [31:0] bst_base(input logic [BST_TGT_W-1:0] idx);
        logic [31:0] a;
        unique case (idx)
            3'd0:    a = 32'h0000_0000;
            3'd1:    a = 32'h1000_0000;
            3'd2:    a = 32'h1100_0000;
            3'd3:    a = 32'h1110_0000;
            3'd4:    a = 32'h2000_0000;
            3'd5:    a = 32'h3000_0000;
            3'd6:    a = 32'h4000_0000;
            default: a = 32'h4100_0000;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/bst_pattern.sv
`timescale 1ns/1ps
module bst_pattern #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TGT_W  = 3,
    parameter int unsigned BEAT_W = 7
) (
    input  logic [TGT_W-1:0]  tgt,
    input  logic [BEAT_W-1:0] beat,
    output logic [DATA_W-1:0] word
);
    // Deterministic beat word: target in the top byte, fixed marker, beat number.
    always_comb begin
        word        = '0;
        word[31:24] = 8'(tgt);
        word[23:16] = 8'hC3;
        word[15:0]  = 16'(beat);
    end
endmodule

// File: rtl/bst_beat_ctr.sv
`timescale 1ns/1ps
module bst_beat_ctr #(
    parameter int unsigned LEN = 128,
    localparam int unsigned BEAT_W = $clog2(LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [BEAT_W-1:0] beat,
    output logic              last
);
    logic [BEAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= (cnt_q == BEAT_W'(LEN-1)) ? '0 : cnt_q + 1'b1;
        end
    end

    assign beat = cnt_q;
    assign last = (cnt_q == BEAT_W'(LEN-1));
endmodule

// File: rtl/bst_verdict.sv
`timescale 1ns/1ps
module bst_verdict #(
    parameter int unsigned ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_i,
    input  logic             err_i,
    input  logic             finish_i,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o,
    output logic [ERR_W-1:0] err_cnt_o
);
    logic             done_q, pass_q, fail_q, bad_q;
    logic [ERR_W-1:0] err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            bad_q  <= 1'b0;
            err_q  <= '0;
        end else if (!done_q) begin
            if (fault_i) begin
                bad_q <= 1'b1;
            end
            if (err_i && (err_q != {ERR_W{1'b1}})) begin
                err_q <= err_q + 1'b1;
            end
            if (finish_i) begin
                done_q <= 1'b1;
                pass_q <= !(bad_q || fault_i);
                fail_q <= bad_q || fault_i;
            end
        end
    end

    assign done_o    = done_q;
    assign pass_o    = pass_q;
    assign fail_o    = fail_q;
    assign err_cnt_o = err_q;

    // R7: verdict flags exclusive and silent until the run ends
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && fail_q));
    a_r7_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> (!pass_q && !fail_q));
    // R8: status frozen once done
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> (done_q && $stable(pass_q) && $stable(fail_q) && $stable(err_q)));
endmodule

// File: rtl/axi_burst_selftest.sv
`timescale 1ns/1ps
module axi_burst_selftest
    import bst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned BURST_LEN = 128,
    parameter int unsigned ERR_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [7:0]          m_arlen,
    output logic [2:0]          m_arsize,
    output logic [1:0]          m_arburst,
    output logic                m_arvalid,
    input  logic                m_arready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic [1:0]          m_rresp,
    input  logic                m_rlast,
    input  logic                m_rvalid,
    output logic                m_rready,
    output logic                test_done,
    output logic                test_pass,
    output logic                test_fail,
    output logic [ERR_W-1:0]    resp_err_count
);
    localparam int unsigned TGT_W    = BST_TGT_W;
    localparam int unsigned BEAT_W   = $clog2(BURST_LEN);
    localparam logic [7:0]  LEN_CODE = 8'(BURST_LEN - 1);
    localparam logic [2:0]  SIZE_CODE = 3'($clog2(DATA_W / 8));
    localparam logic [1:0]  BURST_INCR = 2'b01;
    localparam logic [1:0]  RESP_OKAY  = 2'b00;

    bst_state_e         state_q, state_d;
    logic [TGT_W-1:0]   tgt_q;
    logic [BEAT_W-1:0]  beat;
    logic               beat_last;
    logic               last_tgt;
    logic [DATA_W-1:0]  pat_word;
    logic [ADDR_W-1:0]  base_addr;

    logic aw_hs, w_hs, b_hs, ar_hs, r_hs;
    logic b_err, r_err, r_bad, finish;

    assign last_tgt  = (tgt_q == TGT_W'(BST_NUM_TGT - 1));
    assign base_addr = ADDR_W'(bst_base(tgt_q));

    assign aw_hs = (state_q == ST_AW) && m_awready;
    assign w_hs  = (state_q == ST_W)  && m_wready;
    assign b_hs  = (state_q == ST_B)  && m_bvalid;
    assign ar_hs = (state_q == ST_AR) && m_arready;
    assign r_hs  = (state_q == ST_R)  && m_rvalid;

    // ---------------- beat counter and pattern ----------------
    bst_beat_ctr #(.LEN(BURST_LEN)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (aw_hs || ar_hs),
        .inc   (w_hs || r_hs),
        .beat  (beat),
        .last  (beat_last)
    );

    bst_pattern #(.DATA_W(DATA_W), .TGT_W(TGT_W), .BEAT_W(BEAT_W)) u_pat (
        .tgt  (tgt_q),
        .beat (beat),
        .word (pat_word)
    );

    // ---------------- fault detection ----------------
    assign b_err  = b_hs && (m_bresp != RESP_OKAY);
    assign r_err  = r_hs && (m_rresp != RESP_OKAY);
    assign r_bad  = r_hs && ((m_rdata != pat_word) || (m_rlast != beat_last) || r_err);
    assign finish = r_hs && beat_last && last_tgt;

    bst_verdict #(.ERR_W(ERR_W)) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_i   (b_err || r_bad),
        .err_i     (b_err || r_err),
        .finish_i  (finish),
        .done_o    (test_done),
        .pass_o    (test_pass),
        .fail_o    (test_fail),
        .err_cnt_o (resp_err_count)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_AW;
            ST_AW:   if (aw_hs) state_d = ST_W;
            ST_W:    if (w_hs && beat_last) state_d = ST_B;
            ST_B:    if (b_hs) state_d = last_tgt ? ST_AR : ST_AW;
            ST_AR:   if (ar_hs) state_d = ST_R;
            ST_R:    if (r_hs && beat_last) state_d = last_tgt ? ST_DONE : ST_AR;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state and target registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (b_hs || (r_hs && beat_last)) begin
                tgt_q <= last_tgt ? '0 : tgt_q + 1'b1;
            end
        end
    end

    // ---------------- channel outputs ----------------
    always_comb begin
        m_awaddr  = base_addr;
        m_awlen   = LEN_CODE;
        m_awsize  = SIZE_CODE;
        m_awburst = BURST_INCR;
        m_araddr  = base_addr;
        m_arlen   = LEN_CODE;
        m_arsize  = SIZE_CODE;
        m_arburst = BURST_INCR;
        m_wdata   = pat_word;
        m_wstrb   = '1;
        m_wlast   = 1'b0;
        m_awvalid = 1'b0;
        m_wvalid  = 1'b0;
        m_bready  = 1'b0;
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        unique case (state_q)
            ST_AW: m_awvalid = 1'b1;
            ST_W: begin
                m_wvalid = 1'b1;
                m_wlast  = beat_last;
            end
            ST_B:  m_bready  = 1'b1;
            ST_AR: m_arvalid = 1'b1;
            ST_R:  m_rready  = 1'b1;
            default: ;
        endcase
    end

    // R1: write address held until accepted
    a_r1_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
    // R5: a failed write response is counted
    a_r5_berr_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bready && (m_bresp != RESP_OKAY)) |=> (resp_err_count != '0));
    // R8: no new requests after the verdict
    a_r8_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        test_done |-> (!m_awvalid && !m_wvalid && !m_arvalid));
    // R10: one channel active at a time
    a_r10_single_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready}) <= 1);
endmodule

// File: tb/sim_axi_burst_selftest.sv
`timescale 1ns/1ps
module sim_axi_burst_selftest;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [31:0] m_awaddr, m_araddr, m_wdata, m_rdata;
    logic [7:0]  m_awlen, m_arlen, resp_err_count;
    logic [2:0]  m_awsize, m_arsize;
    logic [1:0]  m_awburst, m_arburst, m_bresp, m_rresp;
    logic [3:0]  m_wstrb;
    logic m_awvalid, m_awready, m_wlast, m_wvalid, m_wready, m_bvalid, m_bready;
    logic m_arvalid, m_arready, m_rlast, m_rvalid, m_rready;
    logic test_done, test_pass, test_fail;

    axi_burst_selftest u0 (
        .clk(clk), .rst_n(rst_n),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
        .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .test_done(test_done), .test_pass(test_pass), .test_fail(test_fail),
        .resp_err_count(resp_err_count)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    localparam logic [31:0] BASES [8] = '{32'h0000_0000, 32'h1000_0000, 32'h1100_0000,
        32'h1110_0000, 32'h2000_0000, 32'h3000_0000, 32'h4000_0000, 32'h4100_0000};

    function automatic int decode(input logic [31:0] a);
        for (int i = 0; i < 8; i++) if (BASES[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [31:0] expect_word(input int t, input int b);
        return {8'(t), 8'hC3, 16'(b)};
    endfunction

    // fault kinds: 0 none, 1 corrupt read data, 2 write-response error,
    // 3 one read-response error, 4 early RLAST, 5 missing RLAST, 6 errors on a whole read burst
    typedef struct packed {
        logic [2:0] kind;
        logic [2:0] tgt;
        logic [6:0] beat;
        logic       stall;
        logic       exp_pass;
        logic [7:0] exp_err;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 3'd0, 7'd0,   1'b0, 1'b1, 8'd0},
        '{3'd0, 3'd0, 7'd0,   1'b1, 1'b1, 8'd0},
        '{3'd1, 3'd3, 7'd64,  1'b0, 1'b0, 8'd0},
        '{3'd1, 3'd7, 7'd127, 1'b1, 1'b0, 8'd0},
        '{3'd1, 3'd0, 7'd0,   1'b0, 1'b0, 8'd0},
        '{3'd2, 3'd5, 7'd0,   1'b0, 1'b0, 8'd1},
        '{3'd3, 3'd2, 7'd10,  1'b1, 1'b0, 8'd1},
        '{3'd4, 3'd0, 7'd50,  1'b0, 1'b0, 8'd0},
        '{3'd5, 3'd6, 7'd0,   1'b1, 1'b0, 8'd0},
        '{3'd6, 3'd4, 7'd0,   1'b0, 1'b0, 8'd128}
    };

    function automatic string kind_req(input logic [2:0] k);
        case (k)
            3'd1: return "R4";
            3'd2, 3'd3, 3'd6: return "R5";
            3'd4, 3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // slave model configuration and state
    logic [2:0]  inj_kind = '0;
    int          inj_tgt = 0, inj_beat = 0;
    bit          stall = 0;
    logic [31:0] mem [1024];
    int aw_seen, ar_seen, b_done;
    int wr_tgt, wr_beat, rd_tgt, rd_beat;
    bit wr_active, b_pend, rd_active, r_gap;
    logic [15:0] lfsr;

    initial begin : slave
        bit aw_h, w_h, b_h, ar_h, r_h;
        logic [31:0] c_awaddr, c_araddr, c_wdata;
        logic [7:0]  c_awlen, c_arlen;
        logic [2:0]  c_awsize, c_arsize;
        logic [1:0]  c_awburst, c_arburst;
        logic [3:0]  c_wstrb;
        logic        c_wlast;
        int idx;
        m_awready = 0; m_wready = 0; m_bvalid = 0; m_bresp = 0;
        m_arready = 0; m_rvalid = 0; m_rdata = 0; m_rresp = 0; m_rlast = 0;
        lfsr = 16'hACE1;
        forever begin
            @(negedge clk);
            aw_h = m_awvalid && m_awready; w_h = m_wvalid && m_wready;
            b_h = m_bvalid && m_bready; ar_h = m_arvalid && m_arready;
            r_h = m_rvalid && m_rready;
            c_awaddr = m_awaddr; c_awlen = m_awlen; c_awsize = m_awsize; c_awburst = m_awburst;
            c_araddr = m_araddr; c_arlen = m_arlen; c_arsize = m_arsize; c_arburst = m_arburst;
            c_wdata = m_wdata; c_wstrb = m_wstrb; c_wlast = m_wlast;
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (!rst_n) begin
                aw_seen = 0; ar_seen = 0; b_done = 0;
                wr_active = 0; b_pend = 0; rd_active = 0; r_gap = 0;
                wr_beat = 0; rd_beat = 0; wr_tgt = 0; rd_tgt = 0;
                m_awready = 0; m_wready = 0; m_bvalid = 0; m_arready = 0; m_rvalid = 0;
                m_bresp = 0; m_rresp = 0; m_rlast = 0;
                continue;
            end
            if (aw_h) begin
                idx = decode(c_awaddr);
                check(idx == aw_seen, "R1", "write address order", c_awaddr, (aw_seen < 8) ? BASES[aw_seen] : 0);
                check(c_awlen == 8'd127 && c_awburst == 2'b01 && c_awsize == 3'd2, "R1", "write len/burst/size",
                      {c_awlen, 6'(c_awburst), 8'(c_awsize)}, {8'd127, 6'd1, 8'd2});
                wr_active = 1; wr_tgt = (idx < 0) ? 0 : idx; wr_beat = 0; aw_seen++;
            end
            if (w_h) begin
                check(c_wdata == expect_word(wr_tgt, wr_beat), "R2", "write data", c_wdata, expect_word(wr_tgt, wr_beat));
                check(c_wstrb == 4'hF && c_wlast == (wr_beat == 127), "R2", "strobes/WLAST",
                      {c_wstrb, 3'b0, c_wlast}, {4'hF, 3'b0, 1'(wr_beat == 127)});
                mem[wr_tgt*128 + wr_beat] = c_wdata;
                if (wr_beat == 127) begin wr_active = 0; b_pend = 1; end
                else wr_beat++;
            end
            if (b_h) begin b_pend = 0; b_done++; end
            if (ar_h) begin
                idx = decode(c_araddr);
                check(b_done == 8, "R3", "reads start after all write responses", b_done, 8);
                check(idx == ar_seen, "R3", "read address order", c_araddr, (ar_seen < 8) ? BASES[ar_seen] : 0);
                check(c_arlen == 8'd127 && c_arburst == 2'b01 && c_arsize == 3'd2, "R3", "read len/burst/size",
                      {c_arlen, 6'(c_arburst), 8'(c_arsize)}, {8'd127, 6'd1, 8'd2});
                rd_active = 1; rd_tgt = (idx < 0) ? 0 : idx; rd_beat = 0; ar_seen++;
            end
            r_gap = 0;
            if (r_h) begin
                if (rd_beat == 127) rd_active = 0;
                else rd_beat++;
                r_gap = stall && lfsr[0];
            end
            m_awready = !wr_active && !b_pend && (!stall || lfsr[2]);
            m_wready  = wr_active && (!stall || lfsr[1]);
            m_bvalid  = b_pend;
            m_bresp   = (inj_kind == 3'd2 && wr_tgt == inj_tgt) ? 2'b10 : 2'b00;
            m_arready = !rd_active && (!stall || lfsr[3]);
            m_rvalid  = rd_active && !r_gap;
            m_rdata   = mem[rd_tgt*128 + rd_beat];
            if (inj_kind == 3'd1 && rd_tgt == inj_tgt && rd_beat == inj_beat) m_rdata = m_rdata ^ 32'h0000_0100;
            m_rresp = 2'b00;
            if (inj_kind == 3'd3 && rd_tgt == inj_tgt && rd_beat == inj_beat) m_rresp = 2'b10;
            if (inj_kind == 3'd6 && rd_tgt == inj_tgt) m_rresp = 2'b11;
            m_rlast = (rd_beat == 127);
            if (inj_kind == 3'd4 && rd_tgt == inj_tgt && rd_beat == inj_beat) m_rlast = 1'b1;
            if (inj_kind == 3'd5 && rd_tgt == inj_tgt && rd_beat == 127) m_rlast = 1'b0;
        end
    end

    task automatic wait_done(input string req, output bit ok);
        ok = 0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (c == 200)
                check(!test_done && !test_pass && !test_fail, "R7", "status low mid-run",
                      {test_done, test_pass, test_fail}, 0);
            if (test_done) begin ok = 1; break; end
        end
        check(ok, req, "run reached done", ok, 1);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        check(!test_done && !test_pass && !test_fail && resp_err_count == 0, "R9", "status after reset",
              {test_done, test_pass, test_fail, resp_err_count}, 0);
        check(!m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready, "R9", "channels idle in reset",
              {m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 0);
        rst_n = 1;
    endtask

    initial begin : main
        bit ok;
        logic [10:0] snap;
        for (int v = 0; v < NVEC; v++) begin
            inj_kind = VECS[v].kind; inj_tgt = VECS[v].tgt; inj_beat = VECS[v].beat; stall = VECS[v].stall;
            do_reset();
            wait_done("R7", ok);
            check(test_pass == VECS[v].exp_pass, kind_req(VECS[v].kind), "pass flag", test_pass, VECS[v].exp_pass);
            check(test_fail == !VECS[v].exp_pass, kind_req(VECS[v].kind), "fail flag", test_fail, !VECS[v].exp_pass);
            check(resp_err_count == VECS[v].exp_err, "R5", "error count", resp_err_count, VECS[v].exp_err);
            check(aw_seen == 8, "R1", "write bursts issued", aw_seen, 8);
            check(ar_seen == 8, "R3", "read bursts issued", ar_seen, 8);
            snap = {test_done, test_pass, test_fail, resp_err_count};
            repeat (20) @(negedge clk);
            check({test_done, test_pass, test_fail, resp_err_count} == snap, "R8", "status held after done",
                  {test_done, test_pass, test_fail, resp_err_count}, snap);
            check(!m_awvalid && !m_arvalid && !m_wvalid && aw_seen == 8 && ar_seen == 8, "R8", "no requests after done",
                  {m_awvalid, m_arvalid, m_wvalid}, 0);
        end

        // directed: reset in the middle of a run, then a clean rerun from target 0
        inj_kind = 0; stall = 1;
        do_reset();
        repeat (700) @(negedge clk);
        rst_n = 0; #2;
        check(!test_done && !test_pass && !test_fail && resp_err_count == 0, "R9", "status cleared mid-run",
              {test_done, test_pass, test_fail, resp_err_count}, 0);
        check(!m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready, "R9", "channels dropped mid-run",
              {m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        wait_done("R9", ok);
        check(test_pass && !test_fail, "R9", "clean rerun passes", {test_pass, test_fail}, 2'b10);
        check(aw_seen == 8 && ar_seen == 8, "R9", "rerun bursts", {16'(aw_seen), 16'(ar_seen)}, {16'd8, 16'd8});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule